// File: doc/BRIEF.md
# Clock-Buffer Output-Enable Serial Register

This block is the configuration slave of a clock fan-out buffer. It watches a two-wire SMBus segment through its SCL and SDA inputs, and it recognises one fixed 7-bit device address. It takes a write transaction as a stream of bytes and keeps the enable settings of thirteen buffer outputs. The output stage uses the resulting vector to gate each complementary output pair and the feedback output.

The block runs on a system clock that is much faster than SCL. Both bus lines go through two-flop synchronisers, and the block detects START, STOP and SCL edges from the synchronised values. The first byte after the address is a command/count byte and is thrown away. The byte after it is stream index 0, and each later byte takes the next index. Only indices 6 and 7 carry enable bits. Every other data byte is acknowledged and dropped. The acknowledge is an active-low pull on the open-drain data line. A new enable value reaches the output at the start of the acknowledge of the byte that carries it.

Top module: `clkbuf_oe_smbus`

## Requirements
- R1: After reset all 13 bits of `oe_vec` are 1 (every output active) and `sda_pull` is 0.
- R2: A write addressed to 7'b1101001 with R/W bit 0 (first byte 0xD2) is acknowledged: `sda_pull` is 1 throughout the ninth SCL clock of the address byte and of every following data byte, and 0 again once SCL falls at the end of that clock.
- R3: A first byte with a different address, or with R/W bit 1 (0xD3), is not acknowledged. The block then ignores the bus, so `oe_vec` keeps its value until the next START.
- R4: Each byte is shifted in most significant bit first.
- R5: The first data byte after the address is discarded. At stream index 6, bit 4 is stored into `oe_vec[12]` (feedback output) and bits 3..0 into `oe_vec[11:8]` (pairs 11..8). At stream index 7, bits 7..0 are stored into `oe_vec[7:0]` (pairs 7..0).
- R6: Bits 7..5 of the index-6 byte are reserved. They have no effect on `oe_vec`.
- R7: Data bytes at any index other than 6 and 7, including indices beyond 7, are acknowledged and change nothing.
- R8: A START, including a repeated START, and a STOP both clear the byte and bit position. The next transaction starts again with an address byte followed by a command byte.
- R9: `oe_vec` changes only in the clock in which `sda_pull` rises for the acknowledge of the byte that carries the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad (wired-AND value) |
| sda_pull | output | 1 | 1 pulls the data line low (acknowledge) |
| oe_vec | output | 13 | Output enables: bit 12 feedback, bits 11..0 output pairs 11..0 |

## Verification
Every result of this block follows an SCL falling edge. The synchroniser, the edge-detect register and the state register together put the matching change of `sda_pull` and `oe_vec` three system clocks after the clock in which the bench lowers SCL. The bench's behavioural slave model sets its expected values in the very cycle it lowers SCL. Those values pass through a three-stage delay line, and the outputs are compared against the delay line's end at every falling clock edge. As a result, an update that comes one cycle early or late, or that is lost, shows up as a mismatch. Acknowledge levels are also sampled on the wired-AND line in the middle of the ninth SCL high phase, and the final enable vectors are checked against constants derived from the requirements.

// File: rtl/clkbuf_oe_smbus.sv
module clkbuf_oe_smbus #(
  parameter logic [6:0] DEV_ADDR  = 7'b1101001,
  parameter int         HI_INDEX  = 6,
  parameter int         POS_W     = 4,
  parameter int         HI_W      = 5,
  parameter int         LO_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 sda_pull,
  output logic [HI_W+LO_W-1:0] oe_vec
);

  localparam int HI_POS = HI_INDEX + 1;
  localparam int LO_POS = HI_INDEX + 2;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_BITS, ST_HOLD, ST_ACK} st_t;

  logic [2:0] scl_p, sda_p;
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       scl_rise, scl_fall, start_det, stop_det;

  st_t              st;
  logic [2:0]       bitcnt;
  logic [7:0]       shreg;
  logic [7:0]       nb;
  logic             addr_ph;
  logic             ack_ok;
  logic [POS_W-1:0] pos;
  logic [HI_W-1:0]  hi_r;
  logic [LO_W-1:0]  lo_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  assign scl_s = scl_p[1];
  assign scl_q = scl_p[2];
  assign sda_s = sda_p[1];
  assign sda_q = sda_p[2];

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  assign nb     = {shreg[6:0], sda_s};
  assign oe_vec = {hi_r, lo_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      addr_ph  <= 1'b1;
      ack_ok   <= 1'b0;
      pos      <= '0;
      sda_pull <= 1'b0;
      hi_r     <= '1;
      lo_r     <= '1;
    end else if (start_det) begin
      st       <= ST_BITS;
      bitcnt   <= '0;
      addr_ph  <= 1'b1;
      pos      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      pos      <= '0;
      sda_pull <= 1'b0;
    end else begin
      case (st)
        ST_BITS: if (scl_rise) begin
          shreg  <= nb;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            st     <= ST_HOLD;
            ack_ok <= addr_ph ? (nb[7:1] == DEV_ADDR && !nb[0]) : 1'b1;
          end
        end
        ST_HOLD: if (scl_fall) begin
          if (ack_ok) begin
            st       <= ST_ACK;
            sda_pull <= 1'b1;
            addr_ph  <= 1'b0;
            if (!addr_ph) begin
              if (pos == POS_W'(HI_POS)) hi_r <= shreg[HI_W-1:0];
              if (pos == POS_W'(LO_POS)) lo_r <= shreg[LO_W-1:0];
              if (pos != POS_MAX) pos <= pos + 1'b1;
            end
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_ACK: if (scl_fall) begin
          sda_pull <= 1'b0;
          st       <= ST_BITS;
          bitcnt   <= '0;
        end
        default: ;
      endcase
    end
  end

  // R9
  oe_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_vec) |-> $rose(sda_pull));

  // R2
  ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);

  // R2
  rel_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> (!scl_s || $past(start_det) || $past(stop_det)));

  // R8
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (bitcnt == 3'd0 && pos == '0 && !sda_pull));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !start_det) |=> $stable(oe_vec));

endmodule

// File: tb/clkbuf_oe_smbus_bench.sv
module clkbuf_oe_smbus_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic        scl_m, sda_m;
  logic        sda_pull;
  logic [12:0] oe;
  wire         sda_bus = sda_m & ~sda_pull;

  clkbuf_oe_smbus u_clkbuf_oe_smbus (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull(sda_pull), .oe_vec(oe)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [12:0] m_oe;
  bit          m_pull, m_active, m_addr;
  int          m_pos;
  logic [12:0] d1_oe, d2_oe, d3_oe;
  bit          d1_p, d2_p, d3_p;

  always @(posedge clk) begin
    if (!rst_n) begin
      d1_oe <= 13'h1FFF; d2_oe <= 13'h1FFF; d3_oe <= 13'h1FFF;
      d1_p <= 0; d2_p <= 0; d3_p <= 0;
    end else begin
      d1_oe <= m_oe; d2_oe <= d1_oe; d3_oe <= d2_oe;
      d1_p <= m_pull; d2_p <= d1_p; d3_p <= d2_p;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total += 2;
      if (oe !== d3_oe) begin
        bad++;
        $display("FAIL R9 oe_vec at %0t: actual=%h expected=%h", $time, oe, d3_oe);
      end
      if (sda_pull !== d3_p) begin
        bad++;
        $display("FAIL R2 sda_pull at %0t: actual=%b expected=%b", $time, sda_pull, d3_p);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b0; wt(8); scl_m = 1'b0; wt(4);
    m_addr = 1; m_active = 0; m_pos = 0;
  endtask

  task automatic rstart_c();
    sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(8);
    start_c();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wt(4); scl_m = 1'b1; wt(8); sda_m = 1'b1; wt(8);
    m_active = 0; m_addr = 0; m_pos = 0;
  endtask

  task automatic send_byte(input logic [7:0] v, input string tag);
    bit ack;
    logic [12:0] nxt;
    nxt = m_oe;
    if (m_addr) ack = (v == 8'hD2);
    else if (m_active) begin
      ack = 1;
      if (m_pos == 7) nxt[12:8] = v[4:0];
      if (m_pos == 8) nxt[7:0] = v;
    end else ack = 0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = v[i]; wt(4); scl_m = 1'b1; wt(8); scl_m = 1'b0;
      if (i == 0) begin m_pull = ack; m_oe = nxt; end
      wt(4);
    end
    sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(4);
    chk(tag, {31'd0, sda_bus}, {31'd0, !ack});
    wt(4); scl_m = 1'b0; m_pull = 0; wt(4);
    if (m_addr) begin m_active = ack; m_addr = 0; m_pos = 0; end
    else if (m_active) m_pos++;
  endtask

  task automatic run(input int n, input logic [7:0] v, input string tag);
    for (int k = 0; k < n; k++) send_byte(v, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; scl_m = 1; sda_m = 1;
    m_oe = 13'h1FFF; m_pull = 0; m_active = 0; m_addr = 0; m_pos = 0;
    wt(5);
    chk("R1 oe in reset", {19'd0, oe}, 32'h1FFF);
    chk("R1 pull in reset", {31'd0, sda_pull}, 32'd0);
    rst_n = 1; wt(5);
    chk("R1 oe after reset", {19'd0, oe}, 32'h1FFF);

    // R5 R6 R7: full stream, reserved bits set in index 6
    start_c(); send_byte(8'hD2, "R2 addr ack"); send_byte(8'h08, "R5 cmd ack");
    run(6, 8'hAA, "R7 ack"); send_byte(8'hE5, "R6 ack"); send_byte(8'h3C, "R5 ack");
    stop_c();
    chk("R5 stored enables", {19'd0, oe}, 32'h053C);
    chk("R6 reserved ignored", {27'd0, oe[12:8]}, 32'h05);

    // R3: wrong address
    start_c(); send_byte(8'hD4, "R3 no ack"); run(9, 8'h00, "R3 ignored");
    stop_c();
    chk("R3 wrong address", {19'd0, oe}, 32'h053C);

    // R3: read direction
    start_c(); send_byte(8'hD3, "R3 read no ack"); run(9, 8'h00, "R3 ignored");
    stop_c();
    chk("R3 read bit", {19'd0, oe}, 32'h053C);

    // R7: indices past 7 are acked and dropped
    start_c(); send_byte(8'hD2, "R2 addr ack"); send_byte(8'h0A, "R5 cmd");
    run(6, 8'h00, "R7 ack"); send_byte(8'h1F, "R5 ack"); send_byte(8'hFF, "R5 ack");
    send_byte(8'h00, "R7 extra ack"); send_byte(8'h55, "R7 extra ack");
    stop_c();
    chk("R7 beyond index 7", {19'd0, oe}, 32'h1FFF);

    // R4: MSB first
    start_c(); send_byte(8'hD2, "R2 addr ack"); send_byte(8'h00, "R5 cmd");
    run(6, 8'h00, "R7 ack"); send_byte(8'h01, "R4 ack"); send_byte(8'h01, "R4 ack");
    stop_c();
    chk("R4 bit order", {19'd0, oe}, 32'h0101);

    // R8: repeated START restarts the stream
    start_c(); send_byte(8'hD2, "R2 addr ack"); send_byte(8'h00, "R5 cmd");
    run(4, 8'hFF, "R7 ack");
    rstart_c(); send_byte(8'hD2, "R8 addr ack"); send_byte(8'h00, "R8 cmd");
    run(6, 8'h00, "R7 ack"); send_byte(8'h0A, "R8 ack"); send_byte(8'h81, "R8 ack");
    stop_c();
    chk("R8 repeated start", {19'd0, oe}, 32'h0A81);

    // R8: STOP truncates, next stream restarts at command byte
    start_c(); send_byte(8'hD2, "R2 addr ack"); send_byte(8'h00, "R5 cmd");
    run(5, 8'hFF, "R7 ack");
    stop_c();
    start_c(); send_byte(8'hD2, "R8 addr ack"); send_byte(8'h00, "R8 cmd");
    run(6, 8'h00, "R7 ack"); send_byte(8'h13, "R8 ack");
    stop_c();
    chk("R8 stop restart", {19'd0, oe}, 32'h1381);

    wt(10);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule